// File: doc/BRIEF.md
# Real-Time Clock with Match Interrupt

This block keeps wall time from a 32768 Hz tick enable, in a single clock domain. A prescaler counts ticks inside each second. Each time the prescaler wraps, a 24-bit seconds counter advances by one, and it stops once every bit is set. Software reaches the block through a 16-bit read/write port with four word slots. The slots give access to the prescaler, the low seconds word, and two match values. The slot holding the seconds match value also returns a shadow copy of the top seconds byte.

Reading the low seconds word freezes the top seconds byte into the shadow. Software can then assemble a 24-bit value that is consistent even when the counter advances between the two accesses. An interrupt pulse marks the moment the running time reaches a programmed instant within a 256-second window. That instant is given as a prescaler value plus the low seconds byte. The counters keep running across system resets. Only a power-on reset or an explicit software clear sets them back.

Top module: `rtc_cmp`

## Requirements
- R1: Each clock with `tick` high advances the prescaler by one, wrapping to 0 after 2^PRE_W ticks. The wrap also adds one to the seconds counter. A read of word 0 returns the prescaler in bits PRE_W:1, with bit 0 reading 0.
- R2: After power-on reset (`por_n` low) and system reset, reads return the following. Prescaler 0. Seconds SEC_POR_VAL (default 0). Shadow 0. Word 2 reads all-ones in bits PRE_W:1. The seconds match byte is 0x00. `irq` is low.
- R3: A write to word 0 with wdata bit 0 = 0 clears both the prescaler and the seconds counter, and the clear takes priority over a tick. The same write with bit 0 = 1 changes nothing.
- R4: System reset (`rst_n` low) returns both match values to their R2 values and drops `irq`. It leaves the prescaler, the seconds counter and the shadow unchanged.
- R5: The seconds counter holds at 0xFFFFFF once it gets there, while the prescaler keeps counting.
- R6: A read of word 1 returns seconds bits 15:0 and, in the same clock, copies seconds bits 23:16 into the shadow. A read of word 3 returns the shadow in bits 15:8.
- R7: Word 2 bits PRE_W:1 hold the prescaler match value, and bit 0 reads 0 whatever was written. Word 3 bits 7:0 hold the seconds match byte, and writes to its bits 15:8 are ignored.
- R8: `irq` goes high for exactly one clock, in the clock after a tick. This happens when the tick moves the counters to a state where the prescaler equals its match value and seconds bits 7:0 equal the match byte. Clocks without a tick never raise `irq`.
- R9: A tick that coincides with a write to word 2 or word 3 never raises `irq`, even if the new counter state matches.
- R10: A state where only the prescaler matches, with the seconds byte different, raises no `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; loads counters and shadow |
| rst_n | input | 1 | Asynchronous system reset, active low; match values and irq only |
| tick | input | 1 | One-clock enable at 32768 Hz |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| rd_en | input | 1 | Read strobe; a word-1 read loads the shadow |
| addr | input | 2 | Word index: 0 prescaler, 1 seconds low, 2 prescaler match, 3 shadow/seconds match |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | One-clock match interrupt pulse |

## Verification
The assertions take two things for granted. First, `tick` and the strobes are sampled on the rising edge of `clk`. Second, both resets are asserted together at start-up, so the counters and match values begin from known values. The bench meets both conditions by changing every input just after a rising edge and applying both resets before any traffic. It shortens the prescaler (PRE_W=4) and preloads the seconds counter near full scale through SEC_POR_VAL, so wrap, saturation and match instants are all reached within a few hundred ticks. Reads, writes and ticks are driven only through the port, and a tick is combined with a match-register write only in the case that R9 covers.

// File: rtl/rtc_cmp.sv
module rtc_cmp #(
  parameter int PRE_W = 15,
  parameter logic [23:0] SEC_POR_VAL = 24'h0
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq
);
  localparam int DW    = 16;
  localparam int SEC_W = 24;
  localparam int LO_W  = 16;
  localparam int HI_W  = SEC_W - LO_W;
  localparam int CS_W  = 8;

  logic [PRE_W-1:0] pre, pre_nx, cmp_pre;
  logic [SEC_W-1:0] sec, sec_nx;
  logic [HI_W-1:0]  shadow;
  logic [CS_W-1:0]  cmp_sec;

  wire clr      = wr_en && addr == 2'd0 && !wdata[0];
  wire cmp_wr   = wr_en && addr[1];
  wire sec_full = &sec;
  wire lo_rd    = rd_en && addr == 2'd1;

  always_comb begin
    pre_nx = pre;
    sec_nx = sec;
    if (clr) begin
      pre_nx = '0;
      sec_nx = '0;
    end else if (tick) begin
      pre_nx = pre + PRE_W'(1);
      if (&pre && !sec_full) sec_nx = sec + SEC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre    <= '0;
      sec    <= SEC_POR_VAL;
      shadow <= '0;
    end else begin
      pre <= pre_nx;
      sec <= sec_nx;
      if (lo_rd) shadow <= sec[SEC_W-1:LO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_pre <= '1;
      cmp_sec <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr_en && addr == 2'd2) cmp_pre <= wdata[PRE_W:1];
      if (wr_en && addr == 2'd3) cmp_sec <= wdata[CS_W-1:0];
      irq <= tick && !clr && !cmp_wr &&
             pre_nx == cmp_pre && sec_nx[CS_W-1:0] == cmp_sec;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = DW'({pre, 1'b0});
      2'd1:    rdata = sec[LO_W-1:0];
      2'd2:    rdata = DW'({cmp_pre, 1'b0});
      default: rdata = {shadow, cmp_sec};
    endcase
  end

  // R1
  pre_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !tick && !clr |=> $stable(pre));

  // R5
  sec_sat_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    sec_full && !clr |=> &sec);

  // R6
  shadow_cap_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    lo_rd |=> shadow == $past(sec[SEC_W-1:LO_W]));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    irq |=> !irq);

  // R8
  irq_tick_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    irq |-> $past(tick));

  // R9
  irq_wr_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    irq |-> !$past(cmp_wr));
endmodule

// File: tb/rtc_cmp_tb_top.sv
module rtc_cmp_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, por_n = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, failures = 0, irq_cnt = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  rtc_cmp #(.PRE_W(4), .SEC_POR_VAL(24'hFFFFFD)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (rd_en && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        failures++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic cyc(logic t, logic w, logic r, logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1;
    tick = t; wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask

  task automatic idle(int n);
    repeat (n) cyc(0, 0, 0, 2'd0, 16'h0);
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    cyc(0, 0, 1, a, 16'h0);
    idle(1);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    cyc(0, 1, 0, a, d);
    idle(1);
  endtask

  task automatic ticks(int n);
    repeat (n) cyc(1, 0, 0, 2'd0, 16'h0);
    idle(1);
  endtask

  task automatic chk_irq(int e, string t);
    idle(2);
    checks++;
    if (irq_cnt != e) begin
      failures++;
      $display("FAIL %s: irq pulses actual=%0d expected=%0d", t, irq_cnt, e);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; por_n = 1; rst_n = 1;
    idle(2);
    // R2 reset state
    rd(2'd0, 16'h0000, "R2 prescaler");
    rd(2'd2, 16'h001E, "R2 prescaler match");
    rd(2'd3, 16'h0000, "R2 shadow/match byte");
    chk_irq(0, "R2 irq low");
    // R6 shadow latch
    rd(2'd1, 16'hFFFD, "R6 seconds low");
    rd(2'd3, 16'hFF00, "R6 shadow");
    // R1 counting and wrap
    ticks(5);
    rd(2'd0, 16'h000A, "R1 prescaler=5");
    ticks(11);
    rd(2'd0, 16'h0000, "R1 prescaler wrap");
    rd(2'd1, 16'hFFFE, "R1 seconds increment");
    // R5 saturation
    ticks(32);
    rd(2'd1, 16'hFFFF, "R5 seconds saturated");
    rd(2'd3, 16'hFF00, "R5 shadow saturated");
    ticks(3);
    rd(2'd0, 16'h0006, "R5 prescaler keeps running");
    chk_irq(0, "R10 no match yet");
    // R4 system reset
    wr(2'd2, 16'h000A);
    wr(2'd3, 16'h0055);
    @(posedge clk); #1; rst_n = 0;
    @(posedge clk); #1; rst_n = 1;
    idle(1);
    rd(2'd0, 16'h0006, "R4 prescaler kept");
    rd(2'd2, 16'h001E, "R4 prescaler match reset");
    rd(2'd3, 16'hFF00, "R4 shadow kept, match byte reset");
    rd(2'd1, 16'hFFFF, "R4 seconds kept");
    // R3 software clear
    wr(2'd0, 16'h0001);
    rd(2'd0, 16'h0006, "R3 bit0=1 no effect");
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h0000, "R3 prescaler cleared");
    rd(2'd1, 16'h0000, "R3 seconds cleared");
    rd(2'd3, 16'h0000, "R3 shadow of cleared seconds");
    // R7 match registers
    wr(2'd2, 16'h000B);
    rd(2'd2, 16'h000A, "R7 prescaler match bit0 reads 0");
    wr(2'd3, 16'hAB03);
    rd(2'd3, 16'h0003, "R7 match byte, upper ignored");
    // R8 and R10 match pulse
    ticks(52);
    chk_irq(0, "R10 prescaler-only matches give no irq");
    ticks(1);
    chk_irq(1, "R8 irq on match");
    idle(6);
    chk_irq(1, "R8 single pulse while holding");
    // R9 suppression
    wr(2'd0, 16'h0000);
    ticks(52);
    cyc(1, 1, 0, 2'd3, 16'h0003);
    idle(1);
    chk_irq(1, "R9 write suppresses irq");
    rd(2'd0, 16'h000A, "R9 tick still counted");
    ticks(16);
    chk_irq(1, "R10 second byte mismatch");
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
    end
    report();
  end
endmodule